// File: doc/BRIEF.md
# DMA Descriptor List Generator

This block turns a transfer request into a scatter table for a bus-master DMA engine. A transfer request is a starting physical address, a total byte count and two mode bits. The block writes the table into a descriptor memory through a simple write port. Each table entry covers one memory segment and takes 8 bytes, stored as two 32-bit words. The first word is the segment address. The second word holds the segment length and an end marker. The block never lets a segment run across a 64 KiB physical page boundary.

Generation starts with a one-cycle start pulse and takes two clock cycles per entry. At the end the block pulses `done_o` and shows the number of entries on `entry_cnt_o`. If the table would need more than `MAX_ENTRIES` entries, it pulses `err_o` instead.

Two optional modes change how segments are formed. A mixed mode interleaves short and long segments in a fixed 1-in-4 rhythm, so that the DMA engine can be stressed. A fixed-address mode makes every entry point at the same buffer, so that one 64 KiB area can be reused for a long transfer.

Top module: `prd_table_gen`

## Requirements
- R1: After reset, and whenever no request is in progress, `busy_o`, `done_o`, `err_o` and `mem_we_o` are low. After reset, `entry_cnt_o` is 0.
- R2: The start address has bit 0 cleared before use. In normal mode, the address word of each entry after the first equals the previous address plus the previous segment length.
- R3: In normal mode, each segment length is the smallest of three values: 65536, the bytes remaining, and the bytes left to the next 64 KiB boundary (65536 minus address bits 15:0).
- R4: Bits 15:0 of the count word hold the segment length modulo 65536, so a 65536-byte segment is written as 0. Bits 30:16 of the count word are 0.
- R5: Bit 31 of the count word is 1 only in the entry that uses up the last remaining bytes. It is 0 in every other entry.
- R6: Entry i is written as two writes on consecutive cycles: the address word to word address 2*i, then the count word to 2*i+1. Entries are written in ascending order.
- R7: When the table completes, `done_o` pulses for one cycle and `entry_cnt_o` holds the number of entries. A byte count of 0 writes nothing, pulses `done_o` and gives a count of 0.
- R8: If bytes remain after `MAX_ENTRIES` entries, `err_o` pulses and `done_o` does not. In that case exactly `MAX_ENTRIES` entries are written and `entry_cnt_o` equals `MAX_ENTRIES`.
- R9: When `mix_en_i` is 1, the short length is 2*`mix_sel_i`+2 and the extra gap is 2*`mix_sel_i[2:0]`. Entries whose index modulo 4 equals 2 use a nominal length of 65536 minus the short length minus the gap. All other entries use the short length. The remaining-bytes and boundary limits of R3 still apply.
- R10: When `fixed_en_i` is 1, every address word equals the even start address. The length of each segment is still limited by that address's boundary and by the bytes remaining.
- R11: A start pulse that arrives while `busy_o` is high is ignored. The running table is finished exactly as if that pulse had not occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse; ignored while busy |
| base_addr_i | input | 32 | Starting physical address |
| byte_cnt_i | input | CNT_W | Total bytes to describe |
| mix_en_i | input | 1 | Enable the short/long interleave mode |
| fixed_en_i | input | 1 | Reuse the start address for every entry |
| mix_sel_i | input | 7 | Selects the short length and the gap in mixed mode |
| mem_we_o | output | 1 | Descriptor memory write strobe |
| mem_addr_o | output | $clog2(MAX_ENTRIES)+1 | Descriptor memory word address |
| mem_wdata_o | output | 32 | Descriptor word being written |
| busy_o | output | 1 | A request is being processed |
| done_o | output | 1 | One-cycle pulse: table complete |
| err_o | output | 1 | One-cycle pulse: entry limit exceeded |
| entry_cnt_o | output | $clog2(MAX_ENTRIES)+1 | Number of entries written |

## Verification
The cases that are hardest to reach from the ports are the ones where limits coincide. One is a segment that both reaches a page boundary and uses up the last byte. Another is a table that needs exactly `MAX_ENTRIES` entries, compared with one that needs a single entry more. The bench instantiates the block with `MAX_ENTRIES` set to 8 and a 20-bit count, which makes both outcomes cheap to produce. It then sweeps start addresses near page ends and odd addresses, byte counts around 64 KiB multiples, all four mode combinations and several mixed-mode selectors. Every table word is predicted arithmetically and compared.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned SEG_W = 17;
  localparam logic [SEG_W-1:0] PAGE_BYTES = 17'h10000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CNT,
    ST_DONE,
    ST_ERR
  } gen_state_e;
endpackage

// File: rtl/prd_nominal.sv
module prd_nominal
  import prd_pkg::*;
(
  input  logic             mix_en_i,
  input  logic [6:0]       sel_i,
  input  logic [1:0]       phase_i,
  output logic [SEG_W-1:0] nominal_o
);
  logic [8:0]       short_len;
  logic [3:0]       gap_len;
  logic [SEG_W-1:0] long_len;

  assign short_len = {1'b0, sel_i, 1'b0} + 9'd2;
  assign gap_len   = {sel_i[2:0], 1'b0};
  assign long_len  = PAGE_BYTES - SEG_W'(short_len) - SEG_W'(gap_len);

  always_comb begin
    if (!mix_en_i)            nominal_o = PAGE_BYTES;
    else if (phase_i == 2'd2) nominal_o = long_len;
    else                      nominal_o = SEG_W'(short_len);
  end
endmodule

// File: rtl/prd_seg_calc.sv
module prd_seg_calc
  import prd_pkg::*;
#(
  parameter int unsigned CNT_W = 26
) (
  input  logic [15:0]      addr_lo_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic [SEG_W-1:0] nominal_i,
  output logic [SEG_W-1:0] len_o,
  output logic             last_o
);
  logic [SEG_W-1:0] want;
  logic [SEG_W-1:0] room;

  // clip to remaining bytes, then to the page end
  assign want   = (rem_i < CNT_W'(nominal_i)) ? rem_i[SEG_W-1:0] : nominal_i;
  assign room   = PAGE_BYTES - {1'b0, addr_lo_i};
  assign len_o  = (want > room) ? room : want;
  assign last_o = (rem_i == CNT_W'(len_o));
endmodule

// File: rtl/prd_word_fmt.sv
module prd_word_fmt (
  input  logic        sel_i,
  input  logic [31:0] addr_i,
  input  logic [15:0] len_i,
  input  logic        last_i,
  output logic [31:0] word_o
);
  assign word_o = sel_i ? {last_i, 15'd0, len_i} : addr_i;
endmodule

// File: rtl/prd_table_gen.sv
module prd_table_gen
  import prd_pkg::*;
#(
  parameter int unsigned CNT_W       = 26,
  parameter int unsigned MAX_ENTRIES = 512,
  localparam int unsigned IX_W       = $clog2(MAX_ENTRIES),
  localparam int unsigned MA_W       = IX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      base_addr_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             mix_en_i,
  input  logic             fixed_en_i,
  input  logic [6:0]       mix_sel_i,
  output logic             mem_we_o,
  output logic [MA_W-1:0]  mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IX_W:0]    entry_cnt_o
);
  gen_state_e       state_q, state_d;
  logic [31:0]      addr_q;
  logic [CNT_W-1:0] rem_q;
  logic [IX_W:0]    idx_q;
  logic             mix_q, fixed_q;
  logic [6:0]       sel_q;

  logic [SEG_W-1:0] nominal;
  logic [SEG_W-1:0] seg_len;
  logic             seg_last;
  logic             word_sel;
  logic             at_limit;

  assign at_limit = (idx_q == MAX_ENTRIES[IX_W:0]);

  prd_nominal u_nominal (
    .mix_en_i (mix_q),
    .sel_i    (sel_q),
    .phase_i  (idx_q[1:0]),
    .nominal_o(nominal)
  );

  prd_seg_calc #(.CNT_W(CNT_W)) u_seg_calc (
    .addr_lo_i(addr_q[15:0]),
    .rem_i    (rem_q),
    .nominal_i(nominal),
    .len_o    (seg_len),
    .last_o   (seg_last)
  );

  prd_word_fmt u_word_fmt (
    .sel_i (word_sel),
    .addr_i(addr_q),
    .len_i (seg_len[15:0]),
    .last_i(seg_last),
    .word_o(mem_wdata_o)
  );

  always_comb begin
    state_d  = state_q;
    mem_we_o = 1'b0;
    word_sel = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: begin
        if (rem_q == '0)   state_d = ST_DONE;
        else if (at_limit) state_d = ST_ERR;
        else begin
          mem_we_o = 1'b1;
          state_d  = ST_CNT;
        end
      end
      ST_CNT: begin
        mem_we_o = 1'b1;
        word_sel = 1'b1;
        state_d  = ST_ADDR;
      end
      ST_DONE, ST_ERR: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      mix_q   <= 1'b0;
      fixed_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        addr_q  <= base_addr_i & ~32'd1;
        rem_q   <= byte_cnt_i;
        idx_q   <= '0;
        mix_q   <= mix_en_i;
        fixed_q <= fixed_en_i;
        sel_q   <= mix_sel_i;
      end else if (state_q == ST_CNT) begin
        rem_q <= rem_q - CNT_W'(seg_len);
        idx_q <= idx_q + 1'b1;
        if (!fixed_q) addr_q <= addr_q + 32'(seg_len);
      end
    end
  end

  assign mem_addr_o  = {idx_q[IX_W-1:0], word_sel};
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);
  assign entry_cnt_o = idx_q;
endmodule

// File: rtl/prd_table_gen_chk.sv
module prd_table_gen_chk #(
  parameter int unsigned MAX_ENTRIES = 512,
  localparam int unsigned IX_W       = $clog2(MAX_ENTRIES),
  localparam int unsigned MA_W       = IX_W + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_we_o,
  input logic [MA_W-1:0] mem_addr_o,
  input logic            wd_lsb_i,
  input logic            wd_flag_i,
  input logic [14:0]     wd_rsvd_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic [IX_W:0]   entry_cnt_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !done_o && !err_o));

  p_even_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_addr_o[0]) |-> !wd_lsb_i);

  p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[0]) |-> (wd_rsvd_i == 15'd0));

  p_last_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[0] && wd_flag_i) |-> ##2 done_o);

  p_pair_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_addr_o[0]) |=>
      (mem_we_o && mem_addr_o[0] && mem_addr_o[MA_W-1:1] == $past(mem_addr_o[MA_W-1:1])));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !err_o);

  p_err_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (entry_cnt_o == MAX_ENTRIES[IX_W:0]));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ({1'b0, mem_addr_o[MA_W-1:1]} < MAX_ENTRIES[IX_W:0]));
endmodule

bind prd_table_gen prd_table_gen_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .wd_lsb_i   (mem_wdata_o[0]),
  .wd_flag_i  (mem_wdata_o[31]),
  .wd_rsvd_i  (mem_wdata_o[30:16]),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .entry_cnt_o(entry_cnt_o)
);

// File: tb/prd_table_gen_bench.sv
module prd_table_gen_bench;
  localparam int CW = 20;
  localparam int ME = 8;
  localparam int IXW = $clog2(ME);
  localparam int MAW = IXW + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [31:0]    base = '0;
  logic [CW-1:0]  cnt = '0;
  logic           mix = 1'b0, fixed = 1'b0;
  logic [6:0]     sel = '0;
  logic           we, busy, done, err;
  logic [MAW-1:0] waddr;
  logic [31:0]    wdata;
  logic [IXW:0]   ecnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prd_table_gen #(.CNT_W(CW), .MAX_ENTRIES(ME)) u_prd_table_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .byte_cnt_i(cnt), .mix_en_i(mix), .fixed_en_i(fixed), .mix_sel_i(sel),
    .mem_we_o(we), .mem_addr_o(waddr), .mem_wdata_o(wdata), .busy_o(busy),
    .done_o(done), .err_o(err), .entry_cnt_o(ecnt)
  );

  logic [31:0] cap [2*ME];
  int wr_n;
  int order_bad;

  always @(negedge clk) begin
    if (rst_n && we) begin
      if (int'(waddr) != wr_n) order_bad++;
      cap[waddr] = wdata;
      wr_n++;
    end
  end

  logic [31:0] exp_w [2*ME];
  int exp_n;
  bit exp_err;

  task automatic chk(string tag, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic model(input logic [31:0] b, input longint c, input bit m,
                       input bit f, input int s);
    longint a, rem, len, nom, room, shortl, gap, longl;
    a = longint'(b) & 64'hFFFF_FFFE;
    rem = c;
    exp_n = 0;
    exp_err = 0;
    shortl = 2 * s + 2;
    gap = 2 * (s & 7);
    longl = 65536 - shortl - gap;
    while (rem > 0) begin
      if (exp_n == ME) begin
        exp_err = 1;
        break;
      end
      nom = m ? (((exp_n % 4) == 2) ? longl : shortl) : 65536;
      len = (nom < rem) ? nom : rem;
      room = 65536 - (a & 16'hFFFF);
      if (len > room) len = room;
      exp_w[2*exp_n]   = a[31:0];
      exp_w[2*exp_n+1] = 32'(len & 16'hFFFF) | ((rem == len) ? 32'h8000_0000 : 32'h0);
      rem = rem - len;
      if (!f) a = a + len;
      exp_n++;
    end
  endtask

  task automatic run_case(input logic [31:0] b, input longint c, input bit m,
                          input bit f, input int s, input bit poke);
    bit saw_done, saw_err;
    int got_cnt, nent, guard;
    model(b, c, m, f, s);
    for (int i = 0; i < 2*ME; i++) cap[i] = 32'hDEAD_BEEF;
    wr_n = 0;
    order_bad = 0;
    @(negedge clk);
    base = b; cnt = CW'(c); mix = m; fixed = f; sel = 7'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    saw_done = 0; saw_err = 0; got_cnt = -1; guard = 0;
    if (poke) begin
      @(negedge clk);
      base = 32'h0000_4444; cnt = CW'(2); mix = ~m; fixed = ~f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!saw_done && !saw_err && guard < 200) begin
      @(negedge clk);
      guard++;
      if (done) begin saw_done = 1; got_cnt = int'(ecnt); end
      if (err)  begin saw_err = 1;  got_cnt = int'(ecnt); end
    end
    if (guard >= 200) chk(poke ? "R11" : "R7", "timeout", 1, 0);
    nent = exp_err ? ME : exp_n;
    if (exp_err) begin
      chk("R8", "err pulse", saw_err, 1);
      chk("R8", "no done", saw_done, 0);
      chk("R8", "entry count", got_cnt, ME);
    end else begin
      chk(poke ? "R11" : "R7", "done pulse", saw_done, 1);
      chk("R7", "no err", saw_err, 0);
      chk(poke ? "R11" : "R7", "entry count", got_cnt, exp_n);
    end
    chk("R6", "write count", wr_n, 2*nent);
    chk("R6", "write order", order_bad, 0);
    for (int i = 0; i < nent; i++) begin
      chk(f ? "R10" : "R2", "address word", cap[2*i], exp_w[2*i]);
      chk(m ? "R9" : "R3", "length field", cap[2*i+1][15:0], exp_w[2*i+1][15:0]);
      chk("R4", "reserved bits", cap[2*i+1][30:16], 0);
      chk("R5", "end flag", cap[2*i+1][31], exp_w[2*i+1][31]);
    end
    @(negedge clk);
    chk("R1", "idle after run", {busy, we, done, err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bases [6];
    longint      counts [9];
    int          sels [3];
    bases  = '{32'h0000_0000, 32'h0001_2345, 32'h0000_FFFE,
               32'h0003_8000, 32'hFFFF_0010, 32'h0000_0001};
    counts = '{0, 1, 2, 'hFFFF, 'h10000, 'h10001, 'h2ABCD, 'h80000, 'hFFFFF};
    sels   = '{0, 127, 45};

    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {busy, we, done, err}, 0);
    chk("R1", "reset entry count", ecnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {busy, we, done, err}, 0);

    // R7: zero count gives no entries
    run_case(32'h0000_1000, 0, 0, 0, 0, 0);
    // R3/R4: exactly one full page encodes as zero length
    run_case(32'h0000_0000, 'h10000, 0, 0, 0, 0);
    // R8: exactly ME pages fits, one byte more does not
    run_case(32'h0000_0000, 'h80000, 0, 0, 0, 0);
    run_case(32'h0000_0000, 'h80001, 0, 0, 0, 0);
    // R10: fixed buffer at mid-page
    run_case(32'h0002_8000, 'h30000, 0, 1, 0, 0);
    run_case(32'h0002_8000, 'h48000, 0, 1, 0, 0);
    // R11: start during a run is ignored
    run_case(32'h0000_0000, 'h30000, 0, 0, 0, 1);
    run_case(32'h0001_FFF0, 'h20000, 1, 0, 3, 1);

    // sweep over bases, counts, mode combinations and selectors
    foreach (bases[bi]) begin
      foreach (counts[ci]) begin
        for (int md = 0; md < 4; md++) begin
          if (md[0]) begin
            foreach (sels[si]) run_case(bases[bi], counts[ci], 1'b1, md[1], sels[si], 0);
          end else begin
            run_case(bases[bi], counts[ci], 1'b0, md[1], 60, 0);
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule